// File: doc/BRIEF.md
# BCD Watchdog and Interval Timer

This block counts down a period written as four BCD digits in units of one hundredth of a second. The period spans two byte-wide registers. One register holds the hundredths and tenths digits. The other holds the units and tens of seconds. A 100 Hz tick, given as a one-clock strobe, decrements the count. When the count runs out, the block raises an interrupt and reloads the period on its own.

The timer has two modes.
- **Watchdog mode:** the interrupt stays set until the host touches a period register. Host software must keep touching a period register, either reading or writing it, before the period runs out. If it stops, the interrupt can be used to restart the processor.
- **Interval mode:** the interrupt is a one-cycle pulse on every expiry. The block acts as a periodic timer.

Any access to a period register restarts the countdown and clears a pending interrupt. An enable input freezes the countdown. A period of 00.00 turns the timer off.

Top module: `bwdt_timer`

## Requirements
- R1: After reset, `irq_o` is 0 and both period registers read 0x00.
- R2: An access with `wr_i`=1 stores `wdata_i` in the register chosen by `sel_i`, and a later read returns it. `sel_i`=0 selects the fraction register: bits 3:0 hold hundredths and bits 7:4 hold tenths. `sel_i`=1 selects the seconds register: bits 3:0 hold units and bits 7:4 hold tens. While `acc_i` is high, `rdata_o` shows the selected register.
- R3: Any access, read or write, reloads the countdown from the programmed period and clears `irq_o` on the next clock edge. For a write, the period includes the value being written.
- R4: With `en_i` high, each tick decrements the count by one. The P-th tick after a reload expires the period, and `irq_o` is high from the clock edge of that tick.
- R5: The count decrements as four BCD digits, borrowing from one digit to the next. A period of 00.10 expires on the 10th tick, and a period of 99.99 expires on the 9999th tick.
- R6: With a programmed period of 00.00, the timer never raises `irq_o`.
- R7: While `en_i` is low, ticks are ignored, the count is frozen, and `irq_o` keeps its value.
- R8: On expiry, the count reloads itself, so the next expiry follows P ticks later with no access in between.
- R9: With `periodic_i`=0 (watchdog mode), `irq_o` stays high after an expiry until an access occurs.
- R10: With `periodic_i`=1 (interval mode), `irq_o` is high for exactly one cycle per expiry.
- R11: When an access and a tick occur in the same cycle, the access wins. The count is reloaded and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised |
| tick_i | input | 1 | 100 Hz count strobe, one clock wide |
| en_i | input | 1 | Countdown enable |
| periodic_i | input | 1 | 0 = watchdog (sticky interrupt), 1 = interval (pulse) |
| acc_i | input | 1 | Host access strobe to a period register |
| wr_i | input | 1 | Access is a write when high |
| sel_i | input | 1 | Register select: 0 = fraction, 1 = seconds |
| wdata_i | input | 8 | Write data, two BCD digits |
| rdata_o | output | 8 | Contents of the selected period register |
| irq_o | output | 1 | Interrupt flag |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- An expiry sets `irq_o` on the same clock edge that samples the expiring tick.
- A write updates the register, and the count is reloaded, on the edge that samples the access.
- The interrupt is cleared on that same edge.
- `rdata_o` follows `sel_i` within the access cycle.

The bench drives every input just after a falling edge and samples just before the next falling edge. Each check therefore sees the state one rising edge after its stimulus. Tick runs are counted edge by edge. The design is probed on the tick just before expiry, where it must still be quiet, and on the expiring tick, where `irq_o` must be high.

// File: rtl/bwdt_pkg.sv
package bwdt_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned BYTE_W  = 8;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // one-digit BCD decrement, wrapping 0 -> 9
  function automatic bcd_t bcd_dec(input bcd_t d);
    return (d == bcd_t'(0)) ? bcd_t'(9) : bcd_t'(d - bcd_t'(1));
  endfunction
endpackage

// File: rtl/bwdt_rst_sync.sv
module bwdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bwdt_period_regs.sv
module bwdt_period_regs
  import bwdt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 2,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned PER_W   = NUM_REGS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [PER_W-1:0]  period_q,
  output logic [PER_W-1:0]  period_nxt
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] reg_q;
  logic [NUM_REGS-1:0][BYTE_W-1:0] reg_nxt;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb begin
      reg_nxt[i] = reg_q[i];
      if (wr_en && (sel == SEL_W'(i))) reg_nxt[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[i] <= '0;
      else        reg_q[i] <= reg_nxt[i];
    end
  end

  assign rdata      = reg_q[sel];
  assign period_q   = reg_q;
  assign period_nxt = reg_nxt;
endmodule

// File: rtl/bwdt_bcd_down.sv
module bwdt_bcd_down
  import bwdt_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned CNT_W = DIGITS * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] dec_val;
  logic [CNT_W-1:0] cnt_nxt;
  logic [DIGITS:0]  borrow;

  assign borrow[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_t cur;
    assign cur = cnt_q[d*DIGIT_W +: DIGIT_W];
    assign dec_val[d*DIGIT_W +: DIGIT_W] = borrow[d] ? bcd_dec(cur) : cur;
    assign borrow[d+1] = borrow[d] && (cur == bcd_t'(0));
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (load)     cnt_nxt = load_val;
    else if (dec) cnt_nxt = dec_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/bwdt_timer.sv
module bwdt_timer
  import bwdt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 2,
  localparam int unsigned DIGITS  = NUM_REGS * 2,
  localparam int unsigned CNT_W   = DIGITS * DIGIT_W,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              periodic_i,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] period_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             prog_zero;
  logic             at_end;
  logic             step;
  logic             expire;
  logic             irq_q;
  logic             irq_nxt;

  bwdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bwdt_period_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (acc_i && wr_i),
    .sel        (sel_i),
    .wdata      (wdata_i),
    .rdata      (rdata_o),
    .period_q   (period_q),
    .period_nxt (period_nxt)
  );

  // count reaching one (or an unexpected zero) ends the period on this tick
  assign prog_zero = (period_q == '0);
  assign at_end    = (cnt_q[CNT_W-1:1] == '0);
  assign step      = tick_i && en_i && !acc_i && !prog_zero;
  assign expire    = step && at_end;

  bwdt_bcd_down #(.DIGITS(DIGITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (acc_i || expire),
    .load_val (period_nxt),
    .dec      (step && !at_end),
    .cnt_q    (cnt_q)
  );

  always_comb begin
    irq_nxt = irq_q;
    if (acc_i)           irq_nxt = 1'b0;
    else if (expire)     irq_nxt = 1'b1;
    else if (periodic_i) irq_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_nxt;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/bwdt_timer_chk.sv
module bwdt_timer_chk #(
  parameter int unsigned NUM_REGS = 2,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned PER_W   = NUM_REGS * 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tick_i,
  input logic             en_i,
  input logic             periodic_i,
  input logic             acc_i,
  input logic             wr_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [7:0]       wdata_i,
  input logic             irq_o,
  input logic             prog_zero,
  input logic [PER_W-1:0] period_q
);
  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_i && wr_i && sel_i == '0) |=> (period_q[7:0] == $past(wdata_i)));

  // R3
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_i |=> !irq_o);

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> $past(tick_i && en_i && !acc_i));

  // R6
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_zero && !acc_i) |=> !$rose(irq_o));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en_i && !acc_i && !periodic_i) |=> $stable(irq_o));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (periodic_i && irq_o && !tick_i) |=> !irq_o);
endmodule

bind bwdt_timer bwdt_timer_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick_i     (tick_i),
  .en_i       (en_i),
  .periodic_i (periodic_i),
  .acc_i      (acc_i),
  .wr_i       (wr_i),
  .sel_i      (sel_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .prog_zero  (prog_zero),
  .period_q   (period_q)
);

// File: tb/sim_bwdt_timer.sv
module sim_bwdt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       en_i = 1'b1;
  logic       periodic_i = 1'b0;
  logic       acc_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       sel_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  bwdt_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i),
    .periodic_i(periodic_i), .acc_i(acc_i), .wr_i(wr_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic s, input logic [7:0] d);
    acc_i = 1'b1; wr_i = 1'b1; sel_i = s; wdata_i = d;
    @(negedge clk);
    acc_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic read_reg(input logic s, output logic [7:0] d);
    acc_i = 1'b1; wr_i = 1'b0; sel_i = s;
    #1 d = rdata_o;
    @(negedge clk);
    acc_i = 1'b0;
  endtask

  task automatic set_period(input logic [7:0] secs, input logic [7:0] frac);
    write_reg(1'b1, secs);
    write_reg(1'b0, frac);
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq after reset", irq_o, 0);
    read_reg(1'b0, d); check("R1 fraction reg", d, 8'h00);
    read_reg(1'b1, d); check("R1 seconds reg", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    write_reg(1'b0, 8'h34);
    write_reg(1'b1, 8'h12);
    read_reg(1'b0, d); check("R2 fraction readback", d, 8'h34);
    read_reg(1'b1, d); check("R2 seconds readback", d, 8'h12);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    set_period(8'h00, 8'h03);
    run_ticks(2); check("R4 before expiry", irq_o, 0);
    run_ticks(1); check("R4 on 3rd tick", irq_o, 1);
    repeat (4) @(negedge clk);
    run_ticks(2); check("R9 stays set", irq_o, 1);
    read_reg(1'b0, d); check("R3 read clears", irq_o, 0);
    run_ticks(2); check("R3 reload no early irq", irq_o, 0);
    run_ticks(1); check("R3 reload full period", irq_o, 1);
    write_reg(1'b0, 8'h05); check("R3 write clears", irq_o, 0);
    run_ticks(4); check("R3 new value pending", irq_o, 0);
    run_ticks(1); check("R3 new value used", irq_o, 1);
  endtask

  task automatic t_borrow();
    set_period(8'h00, 8'h10);
    run_ticks(9);  check("R5 00.10 before", irq_o, 0);
    run_ticks(1);  check("R5 00.10 expiry", irq_o, 1);
    set_period(8'h99, 8'h99);
    run_ticks(9998); check("R5 99.99 before", irq_o, 0);
    run_ticks(1);    check("R5 99.99 expiry", irq_o, 1);
  endtask

  task automatic t_zero();
    set_period(8'h00, 8'h00);
    run_ticks(300); check("R6 zero period silent", irq_o, 0);
  endtask

  task automatic t_enable();
    set_period(8'h00, 8'h02);
    en_i = 1'b0;
    run_ticks(10); check("R7 ticks ignored", irq_o, 0);
    en_i = 1'b1;
    run_ticks(1); check("R7 count frozen", irq_o, 0);
    run_ticks(1); check("R7 resumes", irq_o, 1);
    en_i = 1'b0;
    run_ticks(3); check("R7 irq held", irq_o, 1);
    en_i = 1'b1;
  endtask

  task automatic t_interval();
    periodic_i = 1'b1;
    set_period(8'h00, 8'h03);
    run_ticks(3); check("R10 pulse on expiry", irq_o, 1);
    @(negedge clk); check("R10 pulse one cycle", irq_o, 0);
    run_ticks(2); check("R8 no early reload expiry", irq_o, 0);
    run_ticks(1); check("R8 auto reload expiry", irq_o, 1);
    periodic_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    set_period(8'h00, 8'h02);
    run_ticks(1);
    tick_i = 1'b1;
    read_reg(1'b0, d);
    tick_i = 1'b0;
    run_ticks(1); check("R11 tick during access ignored", irq_o, 0);
    run_ticks(1); check("R11 full period after access", irq_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_borrow();
    t_zero();
    t_enable();
    t_interval();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule